// File: doc/BRIEF.md
# Process-Tagged Associative Translation Buffer

This block keeps a small set of recent page-to-frame translations next to the memory management unit. Each lookup compares the virtual page number and the current process tag against every stored entry at the same time. The lookup outputs are combinational: a matching valid entry gives its frame number in the cycle the request is presented. When no entry matches, the block raises a miss so that the surrounding logic walks the page table in memory.

Translations are installed through a fill port. When the fill needs a slot, it first reuses an entry that already holds the same page and tag. Otherwise it takes the lowest-numbered empty slot. If there is neither, it takes the slot named by a binary-tree pseudo-LRU state. Every entry carries a process tag, so a context switch only changes the current-tag input. A flush input clears everything for use when tags are not used to separate processes. A separate update port rewrites or invalidates one entry when its page-table entry changes.

The request pins are plain strobes with no back-pressure. The block accepts a lookup, a fill, an update and a flush in every cycle, and any combination of them in the same cycle. The block has no ready output, so nothing upstream ever waits.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: When `lu_valid` is high, `lu_hit` is high in the same cycle exactly when a valid entry holds both `lu_vpn` and a process tag equal to `cur_asid`. `lu_pfn` then carries that entry's frame number, and `lu_pfn` is 0 whenever `lu_hit` is low.
- R3: `lu_miss` is high exactly when `lu_valid` is high and no entry matches. Both `lu_hit` and `lu_miss` are low while `lu_valid` is low.
- R4: An entry whose process tag differs from `cur_asid` never produces a hit, even when its page number matches.
- R5: A fill writes its page, tag and frame in the clock edge that samples it. The fill slot is chosen in this order: first the slot already holding the same page and tag, then the lowest-indexed invalid slot, then the pseudo-LRU victim. A given page and tag therefore never occupies two slots.
- R6: The pseudo-LRU state is a 7-bit heap-ordered tree. Node 1 is the root and the children of node i are 2i and 2i+1. A bit value of 0 sends the victim search to the lower half, selected by a slot-index bit of 0, and a value of 1 sends it to the upper half. The three slot-index bits are used from the top bit down. Touching a slot sets every node on its path to point away from it. A lookup hit touches the hit slot, then a fill touches its slot, in that order within one cycle.
- R7: An update whose page and tag match an entry sets that entry's frame to `upd_pfn`, or clears its valid bit when `upd_inval` is high. An update that matches nothing changes no entry. An update does not touch the tree. A fill in the same cycle is applied after the update.
- R8: `flush` invalidates every entry and clears all tree bits to 0. It overrides any fill or update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_asid | input | 4 | Current process tag used by lookups |
| lu_valid | input | 1 | Lookup request strobe |
| lu_vpn | input | 20 | Page number to translate |
| lu_hit | output | 1 | Lookup matched a valid entry |
| lu_miss | output | 1 | Lookup requested and nothing matched |
| lu_pfn | output | 12 | Frame number of the matching entry, else 0 |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 4 | Process tag to install |
| fill_pfn | input | 12 | Frame number to install |
| upd_valid | input | 1 | Update one existing entry |
| upd_inval | input | 1 | Invalidate the matching entry instead of rewriting it |
| upd_vpn | input | 20 | Page number of the entry to update |
| upd_asid | input | 4 | Process tag of the entry to update |
| upd_pfn | input | 12 | New frame number |
| flush | input | 1 | Invalidate all entries and clear the tree |

## Verification
The hardest case to reach is a full buffer whose eviction order depends on a long mix of hits and fills. A fill that finds a duplicate, a free slot or neither must land in a different slot each time, and only lookups show which slot it took. The stimulus fills all eight slots and then touches chosen slots with lookups. It then forces fresh fills and probes every old page, and later runs a long random mix over a narrow range of pages and tags. In that mix, duplicate fills, evictions, updates of missing entries and flushes occur often. A bench model of the tree predicts every lookup result.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 12;
  localparam int ASID_W = 4;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  tlb_entry_t [N-1:0] ents,
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic [N-1:0]       hit_vec,
  output logic [IW-1:0]      hit_idx,
  output logic               hit_any
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ents[g].valid && (ents[g].vpn == key_vpn) &&
                        (ents[g].asid == key_asid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
    end
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          touch_a,
  input  logic [IW-1:0] way_a,
  input  logic          touch_b,
  input  logic [IW-1:0] way_b,
  output logic [IW-1:0] victim
);
  logic [N-1:1] tree_q, tree_d;

  function automatic logic [N-1:1] touch_path(logic [N-1:1] t, logic [IW-1:0] w);
    logic [N-1:1] r;
    logic [IW-1:0] node;
    r    = t;
    node = IW'(1);
    for (int lvl = 0; lvl < IW; lvl++) begin
      r[node] = ~w[IW-1-lvl];
      node    = {node[IW-2:0], w[IW-1-lvl]};
    end
    return r;
  endfunction

  always_comb begin
    logic [IW-1:0] node;
    victim = '0;
    node   = IW'(1);
    for (int lvl = 0; lvl < IW; lvl++) begin
      victim[IW-1-lvl] = tree_q[node];
      node = {node[IW-2:0], tree_q[node]};
    end
  end

  always_comb begin
    tree_d = tree_q;
    if (touch_a) tree_d = touch_path(tree_d, way_a);
    if (touch_b) tree_d = touch_path(tree_d, way_b);
    if (clear)   tree_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lu_valid,
  input  logic [VPN_W-1:0]  lu_vpn,
  output logic              lu_hit,
  output logic              lu_miss,
  output logic [PFN_W-1:0]  lu_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              upd_valid,
  input  logic              upd_inval,
  input  logic [VPN_W-1:0]  upd_vpn,
  input  logic [ASID_W-1:0] upd_asid,
  input  logic [PFN_W-1:0]  upd_pfn,
  input  logic              flush
);
  localparam int IW = $clog2(N);

  tlb_entry_t [N-1:0] ents;
  logic [N-1:0]  lu_match, fl_match, up_match;
  logic [IW-1:0] lu_idx, fl_idx, up_idx;
  logic          lu_any, fl_any, up_any;
  logic [IW-1:0] free_idx, plru_way, fill_way;
  logic          has_free;

  tlb_match #(.N(N)) u_lu_cmp (
    .ents(ents), .key_vpn(lu_vpn), .key_asid(cur_asid),
    .hit_vec(lu_match), .hit_idx(lu_idx), .hit_any(lu_any));

  tlb_match #(.N(N)) u_fill_cmp (
    .ents(ents), .key_vpn(fill_vpn), .key_asid(fill_asid),
    .hit_vec(fl_match), .hit_idx(fl_idx), .hit_any(fl_any));

  tlb_match #(.N(N)) u_upd_cmp (
    .ents(ents), .key_vpn(upd_vpn), .key_asid(upd_asid),
    .hit_vec(up_match), .hit_idx(up_idx), .hit_any(up_any));

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ents[i].valid) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign fill_way = fl_any ? fl_idx : (has_free ? free_idx : plru_way);

  assign lu_hit  = lu_valid && lu_any;
  assign lu_miss = lu_valid && !lu_any;
  assign lu_pfn  = lu_hit ? ents[lu_idx].pfn : '0;

  tlb_plru #(.N(N)) u_plru (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .touch_a(lu_hit), .way_a(lu_idx),
    .touch_b(fill_valid), .way_b(fill_way),
    .victim(plru_way));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents <= '0;
    end else if (flush) begin
      for (int i = 0; i < N; i++) ents[i].valid <= 1'b0;
    end else begin
      if (upd_valid && up_any) begin
        if (upd_inval) ents[up_idx].valid <= 1'b0;
        else           ents[up_idx].pfn   <= upd_pfn;
      end
      if (fill_valid) begin
        ents[fill_way] <= '{valid: 1'b1, asid: fill_asid,
                            vpn: fill_vpn, pfn: fill_pfn};
      end
    end
  end
endmodule

// File: rtl/tlb_top_chk.sv
module tlb_top_chk
  import tlb_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ASID_W-1:0] cur_asid,
  input logic              lu_valid,
  input logic [VPN_W-1:0]  lu_vpn,
  input logic              lu_hit,
  input logic [PFN_W-1:0]  lu_pfn,
  input logic              fill_valid,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [ASID_W-1:0] fill_asid,
  input logic [PFN_W-1:0]  fill_pfn,
  input logic              upd_valid,
  input logic              upd_inval,
  input logic [VPN_W-1:0]  upd_vpn,
  input logic [ASID_W-1:0] upd_asid,
  input logic              flush,
  input logic [N-1:0]      lu_match
);
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lu_hit);

  a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid) && !$past(flush) && lu_valid &&
     lu_vpn == $past(fill_vpn) && cur_asid == $past(fill_asid))
    |-> (lu_hit && lu_pfn == $past(fill_pfn)));

  a_r7_inval_misses: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid && upd_inval) && !$past(fill_valid) && lu_valid &&
     lu_vpn == $past(upd_vpn) && cur_asid == $past(upd_asid))
    |-> !lu_hit);

  a_r5_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lu_match));

  a_r2_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lu_valid) && lu_valid && $stable(lu_vpn) && $stable(cur_asid) &&
     !$past(fill_valid || upd_valid || flush))
    |-> ($stable(lu_hit) && $stable(lu_pfn)));
endmodule

bind tlb_top tlb_top_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lu_valid(lu_valid),
  .lu_vpn(lu_vpn), .lu_hit(lu_hit), .lu_pfn(lu_pfn),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
  .fill_pfn(fill_pfn), .upd_valid(upd_valid), .upd_inval(upd_inval),
  .upd_vpn(upd_vpn), .upd_asid(upd_asid), .flush(flush),
  .lu_match(lu_match));

// File: tb/tlb_top_tb.sv
`timescale 1ns/1ps
module tlb_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cur_asid = 0;
  logic        lu_valid = 0;
  logic [19:0] lu_vpn = 0;
  logic        lu_hit, lu_miss;
  logic [11:0] lu_pfn;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = 0;
  logic [3:0]  fill_asid = 0;
  logic [11:0] fill_pfn = 0;
  logic        upd_valid = 0, upd_inval = 0;
  logic [19:0] upd_vpn = 0;
  logic [3:0]  upd_asid = 0;
  logic [11:0] upd_pfn = 0;
  logic        flush = 0;

  always #5 clk = ~clk;

  tlb_top dut_i (.*);

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  bit        mv[8];
  bit [3:0]  ma[8];
  bit [19:0] mvp[8];
  bit [11:0] mp[8];
  bit [7:1]  mt;

  function automatic int m_find(bit [19:0] v, bit [3:0] a);
    for (int i = 0; i < 8; i++) if (mv[i] && mvp[i] == v && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic void m_touch(int w);
    int node = 1;
    for (int l = 0; l < 3; l++) begin
      int b = (w >> (2 - l)) & 1;
      mt[node] = (b == 0);
      node = 2 * node + b;
    end
  endfunction

  function automatic int m_victim();
    int node = 1, w = 0;
    for (int l = 0; l < 3; l++) begin
      int b = int'(mt[node]);
      w = 2 * w + b;
      node = 2 * node + b;
    end
    return w;
  endfunction

  task automatic chk(bit ok, string t, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", t, act, exp);
    end
  endtask

  task automatic step(bit lv, bit [19:0] lvp, bit [3:0] ca,
                      bit fv, bit [19:0] fvp, bit [3:0] fa, bit [11:0] fp,
                      bit uv, bit ui, bit [19:0] uvp, bit [3:0] ua, bit [11:0] up,
                      bit fl);
    int k, fw, uk;
    bit eh, em;
    bit [11:0] ep;
    @(negedge clk);
    lu_valid = lv; lu_vpn = lvp; cur_asid = ca;
    fill_valid = fv; fill_vpn = fvp; fill_asid = fa; fill_pfn = fp;
    upd_valid = uv; upd_inval = ui; upd_vpn = uvp; upd_asid = ua; upd_pfn = up;
    flush = fl;
    #1;
    k  = m_find(lvp, ca);
    eh = lv && (k >= 0);
    em = lv && (k < 0);
    ep = eh ? mp[k] : 12'h0;
    chk(lu_hit == eh && lu_miss == em && lu_pfn == ep, tag,
        $sformatf("hit=%0b miss=%0b pfn=%h", lu_hit, lu_miss, lu_pfn),
        $sformatf("hit=%0b miss=%0b pfn=%h", eh, em, ep));
    if (fl) begin
      for (int i = 0; i < 8; i++) mv[i] = 0;
      mt = '0;
    end else begin
      fw = m_find(fvp, fa);
      if (fw < 0) begin
        for (int i = 7; i >= 0; i--) if (!mv[i]) fw = i;
      end
      if (fw < 0) fw = m_victim();
      uk = m_find(uvp, ua);
      if (uv && uk >= 0) begin
        if (ui) mv[uk] = 0; else mp[uk] = up;
      end
      if (fv) begin
        mv[fw] = 1; ma[fw] = fa; mvp[fw] = fvp; mp[fw] = fp;
      end
      if (eh) m_touch(k);
      if (fv) m_touch(fw);
    end
  endtask

  task automatic look(bit [19:0] v, bit [3:0] a);
    step(1, v, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(bit [19:0] v, bit [3:0] a, bit [11:0] p);
    step(0, 0, 0, 1, v, a, p, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic upd(bit inv, bit [19:0] v, bit [3:0] a, bit [11:0] p);
    step(0, 0, 0, 0, 0, 0, 0, 1, inv, v, a, p, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mv[i] = 0;
    mt = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: empty after reset
    tag = "R1";
    look(20'h5, 0); look(20'h0, 0);
    // R3: idle lookup gives neither hit nor miss
    tag = "R3";
    step(0, 20'h5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: fill eight slots, invalid slots used first
    tag = "R5";
    for (int i = 0; i < 8; i++) fill(20'(i), 1, 12'(12'h100 + i));
    // R2: hits return stored frame
    tag = "R2";
    for (int i = 0; i < 8; i++) look(20'(i), 1);
    // R4: other process tag misses
    tag = "R4";
    look(20'h2, 2); look(20'h7, 0);
    // R5: duplicate fill overwrites, then one invalidate removes it entirely
    tag = "R5";
    fill(20'h3, 1, 12'habc); look(20'h3, 1);
    upd(1, 20'h3, 1, 0); look(20'h3, 1);
    fill(20'h3, 1, 12'h103); look(20'h3, 1);
    // R6: touch chosen slots, force evictions, probe all pages
    tag = "R6";
    look(20'h0, 1); look(20'h5, 1); look(20'h2, 1);
    for (int j = 0; j < 3; j++) begin
      fill(20'(20'h40 + j), 1, 12'(12'h200 + j));
      for (int i = 0; i < 8; i++) look(20'(i), 1);
      look(20'(20'h40 + j), 1);
    end
    // R7: rewrite frame, update a missing entry, invalidate
    tag = "R7";
    upd(0, 20'h1, 1, 12'h777); look(20'h1, 1);
    upd(0, 20'h99, 1, 12'h555);
    for (int i = 0; i < 8; i++) look(20'(i), 1);
    upd(1, 20'h1, 2, 0); look(20'h1, 1);
    upd(1, 20'h1, 1, 0); look(20'h1, 1);
    // R8: flush overrides same-cycle fill and clears the tree
    tag = "R8";
    step(0, 0, 0, 1, 20'h50, 1, 12'h333, 1, 0, 20'h0, 1, 12'h1, 1);
    look(20'h50, 1); look(20'h0, 1); look(20'h4, 1);
    for (int i = 0; i < 9; i++) fill(20'(20'h60 + i), 3, 12'(i));
    for (int i = 0; i < 9; i++) look(20'(20'h60 + i), 3);
    // R2: random mix over a narrow key space
    tag = "R2";
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 3) != 0, 20'($urandom_range(0, 15)), 4'($urandom_range(0, 2)),
           r < 30, 20'($urandom_range(0, 15)), 4'($urandom_range(0, 2)), 12'($urandom),
           r >= 30 && r < 45, 1'($urandom), 20'($urandom_range(0, 15)),
           4'($urandom_range(0, 2)), 12'($urandom),
           r == 99);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule